// File: doc/BRIEF.md
# Single-Phase Fan Commutation Controller

This block is the digital control core of a single-phase, full-wave bridge fan driver. It takes a Hall polarity bit from an external comparator, a PWM speed command and a thermal-shutdown flag. From these it produces the drive state of the two bridge legs (high, low or off), an FG rotation output and an RD lock-status output, both open-drain style. The analog Hall amplifier, the linear output stage and the temperature sensor sit outside the block.

The Hall polarity selects the direction of current through the coil. A low PWM level puts the bridge into recirculation, with both legs low. If no Hall transition arrives within a lock window, the bridge is released for a longer pause and then tried again. If PWM stays low during that pause, the core drops into standby. A high PWM level wakes it with a quick start. Every start, whether from standby or from a lock retry, begins with a full-duty kick. All timing is given in clock cycles through parameters.

Top module: `fan_commutator`

## Requirements
- R1: While reset is held, and after it, the core is in standby: both legs are OFF, `fg_pull` is 0 and `rd_pull` is 1. Leg encoding: 2'b10 HIGH, 2'b01 LOW, 2'b00 OFF.
- R2: When driving with Hall polarity 1, OUT1 is HIGH and OUT2 is LOW. With polarity 0, OUT2 is HIGH and OUT1 is LOW. The two legs are never both HIGH.
- R3: In run mode, a low PWM level drives both legs LOW, not OFF.
- R4: Outside standby, `fg_pull` equals the synchronized Hall polarity, so it changes on every commutation.
- R5: If kick or run mode sees no Hall transition for LOCK_ON_CYC cycles, lock-off mode begins. Both legs go OFF and `rd_pull` goes to 0.
- R6: After LOCK_OFF_CYC cycles in lock-off mode, drive is retried through a kick and `rd_pull` returns to 1.
- R7: Standby is entered only from lock-off mode, once PWM has been low for STBY_CYC cycles. A long low PWM level in run mode never causes standby.
- R8: In standby, both legs are OFF, `fg_pull` is 0 and `rd_pull` is 1. The core stays there while PWM is low.
- R9: A high PWM level in standby starts a kick and restarts the lock window.
- R10: A kick drives the bridge at full duty whatever the PWM level. It ends at the first Hall transition or after KICK_MAX_CYC cycles, and the bridge then follows PWM.
- R11: While the thermal flag is high, both legs are OFF. Drive resumes when the flag clears.
- R12: The Hall, PWM and thermal inputs each pass through two flops. A change on any of them shows at the outputs within three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 1 | Hall polarity from external comparator (asynchronous) |
| pwm_in | input | 1 | PWM speed command (asynchronous) |
| tsd_in | input | 1 | Thermal-shutdown flag (asynchronous) |
| out1_drv | output | 2 | OUT1 leg state: 10 HIGH, 01 LOW, 00 OFF |
| out2_drv | output | 2 | OUT2 leg state: 10 HIGH, 01 LOW, 00 OFF |
| fg_pull | output | 1 | 1 = FG open-drain pulls low |
| rd_pull | output | 1 | 1 = RD open-drain pulls low |

## Verification
A wrong mode shows up almost at once. The leg encodings and the two open-drain outputs follow the mode register combinationally, so a wrong mode is visible in the same cycle. Standby and lock-off differ only in `fg_pull` and `rd_pull`, which the bench checks together with the legs. A faulty timer cannot be seen until a window closes, so the bench measures the lock window, the retry pause and the standby delay in cycles against tolerances. It also checks that a long low PWM level in run mode, with Hall transitions still arriving, leaves the bridge recirculating and does not put it into standby.

// File: rtl/fan_pkg.sv
// Shared types for the fan commutation core.
// Assumes: legs use a two-bit encoding read by an external output stage.
package fan_pkg;
    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_HIGH = 2'b10
    } drv_t;

    typedef enum logic [1:0] {
        M_STBY = 2'b00,
        M_KICK = 2'b01,
        M_RUN  = 2'b10,
        M_LOCK = 2'b11
    } mode_t;
endpackage

// File: rtl/fan_sync.sv
// Two-flop synchronizer for a bundle of asynchronous control inputs.
// Assumes: each bit is independent; no bundle coherency is needed.
module fan_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture then re-register each input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fan_seq.sv
// Mode sequencer: standby, kick, run and lock-off, with the lock window,
// the retry pause, the kick limit and the standby delay counters.
// Assumes: synchronized inputs; LOCK_ON_CYC > KICK_MAX_CYC.
module fan_seq
    import fan_pkg::*;
#(
    parameter int LOCK_ON_CYC  = 75_000_000,
    parameter int LOCK_OFF_CYC = 750_000_000,
    parameter int KICK_MAX_CYC = 12_500_000,
    parameter int STBY_CYC     = 93_750
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hall_s,
    input  logic  pwm_s,
    output mode_t mode
);
    localparam int MD_MAX = (LOCK_OFF_CYC > KICK_MAX_CYC) ? LOCK_OFF_CYC : KICK_MAX_CYC;
    localparam int LW = $clog2(LOCK_ON_CYC + 1);
    localparam int MW = $clog2(MD_MAX + 1);
    localparam int SW = $clog2(STBY_CYC + 1);

    logic          hall_q;
    logic          hall_edge;
    logic [LW-1:0] lk_cnt;
    logic [MW-1:0] md_cnt;
    logic [SW-1:0] lo_cnt;
    logic          lk_expired;
    mode_t         nxt;

    assign hall_edge  = hall_s ^ hall_q;
    assign lk_expired = (lk_cnt == LW'(LOCK_ON_CYC - 1)) && !hall_edge;

    // Next-mode decision from the timers and inputs.
    always_comb begin
        nxt = mode;
        case (mode)
            M_STBY: if (pwm_s) nxt = M_KICK;
            M_KICK: begin
                if (lk_expired)
                    nxt = M_LOCK;
                else if (hall_edge || md_cnt == MW'(KICK_MAX_CYC - 1))
                    nxt = M_RUN;
            end
            M_RUN:  if (lk_expired) nxt = M_LOCK;
            M_LOCK: begin
                if (lo_cnt == SW'(STBY_CYC))
                    nxt = M_STBY;
                else if (md_cnt == MW'(LOCK_OFF_CYC - 1))
                    nxt = M_KICK;
            end
            default: nxt = M_STBY;
        endcase
    end

    // Mode register and Hall history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= M_STBY;
            hall_q <= 1'b0;
        end else begin
            mode   <= nxt;
            hall_q <= hall_s;
        end
    end

    // Dwell counter for kick length and retry pause, cleared on mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != mode || !(mode == M_KICK || mode == M_LOCK))
            md_cnt <= '0;
        else
            md_cnt <= md_cnt + 1'b1;
    end

    // Lock window: cleared on kick entry, on each Hall transition and outside drive.
    always_ff @(posedge clk) begin
        if (!rst_n || hall_edge || (nxt == M_KICK && mode != M_KICK)
            || !(mode == M_KICK || mode == M_RUN))
            lk_cnt <= '0;
        else
            lk_cnt <= lk_cnt + 1'b1;
    end

    // Saturating count of cycles with PWM held low.
    always_ff @(posedge clk) begin
        if (!rst_n || pwm_s)
            lo_cnt <= '0;
        else if (lo_cnt != SW'(STBY_CYC))
            lo_cnt <= lo_cnt + 1'b1;
    end

    AST_STBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STBY && pwm_s) |=> mode == M_KICK); // R9
    AST_RUN_NO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RUN) |=> mode != M_STBY); // R7
    AST_LOCK_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOCK && $past(mode) != M_LOCK) |-> $past(lk_cnt) == LW'(LOCK_ON_CYC - 1)); // R5
endmodule

// File: rtl/fan_bridge.sv
// Output encoder: maps mode, Hall polarity, PWM and thermal flag onto the
// two leg states and the open-drain FG/RD controls.
// Assumes: inputs already synchronized; legs are never both HIGH.
module fan_bridge
    import fan_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  hall_s,
    input  logic  pwm_s,
    input  logic  tsd_s,
    output drv_t  leg [2],
    output logic  fg_pull,
    output logic  rd_pull
);
    logic active;
    logic full;

    assign active = (mode == M_KICK || mode == M_RUN) && !tsd_s;
    assign full   = (mode == M_KICK) || pwm_s;

    // One encoder per leg; leg 0 sources on polarity 1, leg 1 on polarity 0.
    for (genvar g = 0; g < 2; g++) begin : g_leg
        logic src;
        assign src = (g == 0) ? hall_s : !hall_s;
        always_comb begin
            if (!active)    leg[g] = DRV_OFF;
            else if (!full) leg[g] = DRV_LOW;
            else if (src)   leg[g] = DRV_HIGH;
            else            leg[g] = DRV_LOW;
        end
    end

    // Open-drain controls from mode and Hall polarity.
    assign fg_pull = (mode != M_STBY) && hall_s;
    assign rd_pull = (mode != M_LOCK);

    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg[0] == DRV_HIGH && leg[1] == DRV_HIGH)); // R2
    AST_TSD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_s |-> (leg[0] == DRV_OFF && leg[1] == DRV_OFF)); // R11
    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_STBY) |-> (leg[0] == DRV_OFF && !fg_pull && rd_pull)); // R8
endmodule

// File: rtl/fan_commutator.sv
// Top of the single-phase fan commutation core: synchronizes the inputs,
// sequences the modes and encodes the bridge and status outputs.
// Assumes: one clock domain; all timing parameters are in clock cycles.
module fan_commutator
    import fan_pkg::*;
#(
    parameter int LOCK_ON_CYC  = 75_000_000,
    parameter int LOCK_OFF_CYC = 750_000_000,
    parameter int KICK_MAX_CYC = 12_500_000,
    parameter int STBY_CYC     = 93_750
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hall_in,
    input  logic       pwm_in,
    input  logic       tsd_in,
    output logic [1:0] out1_drv,
    output logic [1:0] out2_drv,
    output logic       fg_pull,
    output logic       rd_pull
);
    logic [2:0] sync_q;
    mode_t      mode;
    drv_t       leg [2];

    fan_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tsd_in, pwm_in, hall_in}),
        .q     (sync_q)
    );

    fan_seq #(
        .LOCK_ON_CYC  (LOCK_ON_CYC),
        .LOCK_OFF_CYC (LOCK_OFF_CYC),
        .KICK_MAX_CYC (KICK_MAX_CYC),
        .STBY_CYC     (STBY_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hall_s (sync_q[0]),
        .pwm_s  (sync_q[1]),
        .mode   (mode)
    );

    fan_bridge u_bridge (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .hall_s  (sync_q[0]),
        .pwm_s   (sync_q[1]),
        .tsd_s   (sync_q[2]),
        .leg     (leg),
        .fg_pull (fg_pull),
        .rd_pull (rd_pull)
    );

    assign out1_drv = leg[0];
    assign out2_drv = leg[1];

    AST_LOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_LOCK) |-> (out1_drv == 2'b00 && out2_drv == 2'b00 && !rd_pull)); // R5
endmodule

// File: tb/fan_commutator_bench.sv
// Scoreboard bench: driver tasks queue expected port values, a monitor
// pops and compares them on the falling edge.
module fan_commutator_bench;
    localparam int LON  = 60;
    localparam int LOFF = 600;
    localparam int KMAX = 20;
    localparam int STBY = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hall_in = 1'b0;
    logic       pwm_in = 1'b0;
    logic       tsd_in = 1'b0;
    logic [1:0] out1_drv, out2_drv;
    logic       fg_pull, rd_pull;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] o1;
        logic [1:0] o2;
        logic       fg;
        logic       rd;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    fan_commutator #(
        .LOCK_ON_CYC(LON), .LOCK_OFF_CYC(LOFF), .KICK_MAX_CYC(KMAX), .STBY_CYC(STBY)
    ) u_fan_commutator (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .pwm_in(pwm_in), .tsd_in(tsd_in),
        .out1_drv(out1_drv), .out2_drv(out2_drv), .fg_pull(fg_pull), .rd_pull(rd_pull)
    );

    // Monitor: compare every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (out1_drv !== e.o1 || out2_drv !== e.o2 || fg_pull !== e.fg || rd_pull !== e.rd) begin
                n_bad++;
                $display("FAIL %s: actual o1=%b o2=%b fg=%b rd=%b expected o1=%b o2=%b fg=%b rd=%b",
                         e.tag, out1_drv, out2_drv, fg_pull, rd_pull, e.o1, e.o2, e.fg, e.rd);
            end
        end
    end

    task automatic push(input logic [1:0] o1, input logic [1:0] o2,
                        input logic fg, input logic rd, input string tag);
        exp_t e;
        e.o1 = o1; e.o2 = o2; e.fg = fg; e.rd = rd; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic h, input logic p, input logic t);
        @(negedge clk);
        #1;
        hall_in = h; pwm_in = p; tsd_in = t;
    endtask

    task automatic check_range(input int v, input int lo, input int hi, input string tag);
        n_chk++;
        if (v < lo || v > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, v, lo, hi);
        end
    endtask

    task automatic wait_rd(input logic val, input int max, output int n);
        n = 0;
        while (rd_pull !== val && n < max) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    localparam logic [1:0] HI = 2'b10, LO = 2'b01, OF = 2'b00;

    initial begin
        int n;
        // R1: reset state
        settle(3);
        push(OF, OF, 1'b0, 1'b1, "R1 during reset");
        drive(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        settle(5);
        push(OF, OF, 1'b0, 1'b1, "R1 after reset");

        // R9 R12 R2: quick start, polarity 0 drives OUT2 high
        drive(1'b0, 1'b1, 1'b0);
        settle(5);
        push(LO, HI, 1'b0, 1'b1, "R9 R2 wake polarity 0");

        // R10: kick ignores low PWM
        drive(1'b0, 1'b0, 1'b0);
        settle(4);
        push(LO, HI, 1'b0, 1'b1, "R10 kick full duty");

        // R3 R4: Hall edge ends kick, low PWM recirculates
        drive(1'b1, 1'b0, 1'b0);
        settle(4);
        push(LO, LO, 1'b1, 1'b1, "R3 R4 recirculation");

        // R2: polarity 1 drives OUT1 high
        drive(1'b1, 1'b1, 1'b0);
        settle(4);
        push(HI, LO, 1'b1, 1'b1, "R2 polarity 1");

        // R5: regular commutation keeps lock away
        for (int i = 0; i < 10; i++) begin
            drive(hall_in ^ 1'b1, 1'b1, 1'b0);
            repeat (10) @(posedge clk);
        end
        settle(4);
        push(HI, LO, 1'b1, 1'b1, "R5 no lock while rotating");

        // R5: stalled rotor enters lock-off
        wait_rd(1'b0, 90, n);
        check_range(n, 1, 80, "R5 lock detect delay");
        push(OF, OF, 1'b1, 1'b0, "R5 lock-off outputs");

        // R6: retry after the off pause
        wait_rd(1'b1, 700, n);
        check_range(n, LOFF - 5, LOFF + 5, "R6 lock-off pause");
        push(HI, LO, 1'b1, 1'b1, "R6 retry kick");

        // R5: lock window measured from the retry
        wait_rd(1'b0, 100, n);
        check_range(n, LON - 3, LON + 3, "R5 lock window length");

        // R7 R8: low PWM in lock-off reaches standby
        drive(1'b1, 1'b0, 1'b0);
        wait_rd(1'b1, 100, n);
        check_range(n, STBY - 2, STBY + 10, "R7 standby delay");
        push(OF, OF, 1'b0, 1'b1, "R8 standby outputs");
        settle(300);
        push(OF, OF, 1'b0, 1'b1, "R8 standby held");

        // R9 R12: quick start within three cycles
        drive(1'b1, 1'b1, 1'b0);
        settle(3);
        push(HI, LO, 1'b1, 1'b1, "R9 R12 quick start");

        // R10: kick limit expires, then bridge follows PWM
        repeat (24) @(posedge clk);
        drive(1'b1, 1'b0, 1'b0);
        settle(4);
        push(LO, LO, 1'b1, 1'b1, "R10 kick limit then recirc");

        // R11: thermal flag releases both legs, drive resumes
        drive(1'b0, 1'b0, 1'b0);
        settle(4);
        push(LO, LO, 1'b0, 1'b1, "R4 polarity 0 fg released");
        drive(1'b0, 1'b1, 1'b1);
        settle(4);
        push(OF, OF, 1'b0, 1'b1, "R11 thermal off");
        drive(1'b0, 1'b1, 1'b0);
        settle(4);
        push(LO, HI, 1'b0, 1'b1, "R11 thermal resume");

        // R7 R3: long low PWM while rotating stays in run
        for (int i = 0; i < 12; i++) begin
            drive(hall_in ^ 1'b1, 1'b0, 1'b0);
            repeat (10) @(posedge clk);
        end
        settle(4);
        push(LO, LO, 1'b0, 1'b1, "R7 R3 run holds under low PWM");

        settle(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule